// File: doc/BRIEF.md
# SMT-Partitioned Return Address Stack

This block predicts return targets for a core that runs two hardware threads. Thirty-two physical entries hold return addresses. While both threads are active, each thread works on its own half of sixteen entries. When one thread stops, the thread that is still running uses all thirty-two entries as one circular stack. A call event pushes its return address. A return event pops the most recent entry, and the prediction appears on the next cycle.

A change of mode recomputes only the stack pointers and leaves every stored entry as it is. Entering single-thread mode keeps the running thread's pointer where it is. A pop that follows soon after can therefore run down past the thread's own half and return addresses that the idle sibling pushed. When both threads are active again, each pointer is folded back into its own half. A fill command writes one safe target into every entry a thread can see, one push per cycle. Software uses it before a thread idles, so that no stale target can be reached.

Top module: `smt_ret_stack`

## Requirements
- R1: When both bits of `active_i` are 1 (dual mode), thread 0 uses physical entries 0–15 and thread 1 uses entries 16–31. Pushes, pops and fills of one thread never change what the other thread pops.
- R2: When exactly one bit of `active_i` is 1 (single mode), the active thread's pointer steps over all 32 entries, so up to 32 pushed addresses come back in reverse order.
- R3: The pointer marks the most recent entry. A push advances the pointer and writes the address there. A pop returns the entry under the pointer and then steps the pointer back.
- R4: `pred_vld_o[t]` is 1 exactly one cycle after an accepted pop of thread t, and `pred_tgt_o` bits [t*32+31:t*32] carry the target in that cycle. After reset, no valid is raised until a pop has been accepted.
- R5: A push and a pop from the same thread in the same cycle return the pushed address and leave that thread's stack unchanged.
- R6: Each stack is circular. A push beyond capacity overwrites the oldest entry, and a pop past the bottom wraps around and returns whatever entry lies there.
- R7: A mode change writes no entry. Entering single mode keeps the pointer. Entering dual mode sets each thread's pointer to its own thread bit followed by the low four bits of the old pointer.
- R8: Straight after entering single mode, thread 0 at entry 0 pops its own entry and then entry 31, which was last written by the now-idle thread 1.
- R9: Push and pop from a thread whose active bit is 0 are ignored. They produce no valid and write no entry.
- R10: A fill request is accepted from an active thread that is not already filling. From the next cycle `fill_busy_o[t]` is 1 for 16 cycles in dual mode or 32 cycles in single mode. Each of those cycles writes `fill_tgt_i`, captured at acceptance, to the next entry. At the end the pointer is back where it started and every entry the thread can see holds the target.
- R11: Push and pop of a thread are ignored in the cycle its fill is accepted and in every cycle its fill is busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| active_i | input | 2 | Per-thread active status (1 = active) |
| push_i | input | 2 | Per-thread call push event |
| push_tgt_i | input | 64 | Per-thread return address to push, thread t in bits [t*32+31:t*32] |
| pop_i | input | 2 | Per-thread return pop request |
| fill_i | input | 2 | Per-thread request to fill the thread's view with a safe target |
| fill_tgt_i | input | 32 | Safe target written by a fill |
| pred_vld_o | output | 2 | Per-thread prediction valid, one cycle after a pop |
| pred_tgt_o | output | 64 | Per-thread predicted return target |
| fill_busy_o | output | 2 | Per-thread fill in progress |

## Verification
A fault in the pointer logic shows up at the ports on the first pop that follows it. A wrong remap on entering dual mode, for example, gives a wrong target on the very next return of that thread. A corrupted entry stays hidden until a pop reaches it, which can be many calls later, so the bench compares every cycle against a behavioural model and deliberately pops across half boundaries and wrap points. A wrong fill length shows at once in the width of the busy pulse, and also as a stale target on the pops that follow the fill.

// File: rtl/smt_rs_pkg.sv
package smt_rs_pkg;

    localparam int NUM_THREADS = 2;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } stack_op_e;

endpackage

// File: rtl/rsb_mode_track.sv
module rsb_mode_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] active_i,
    output logic       dual_o,
    output logic       dual_prev_o,
    output logic       enter_dual_o
);

    typedef struct packed {
        logic dual;
    } mode_state_t;

    mode_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.dual = (active_i == 2'b11);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dual_o       = (active_i == 2'b11);
    assign dual_prev_o  = st_q.dual;
    assign enter_dual_o = dual_o && !st_q.dual;

endmodule

// File: rtl/rsb_ptr_step.sv
module rsb_ptr_step #(
    parameter int IDX_W     = 5,
    parameter int THREAD_ID = 0
) (
    input  logic [IDX_W-1:0] ptr_i,
    input  logic             dual_i,
    input  logic             remap_i,
    output logic [IDX_W-1:0] cur_o,
    output logic [IDX_W-1:0] inc_o,
    output logic [IDX_W-1:0] dec_o
);

    localparam int   LOW_W = IDX_W - 1;
    localparam logic TID   = 1'(THREAD_ID);

    logic [LOW_W-1:0] low;

    always_comb begin
        cur_o = remap_i ? {TID, ptr_i[LOW_W-1:0]} : ptr_i;
        low   = cur_o[LOW_W-1:0];
        if (dual_i) begin
            inc_o = {TID, low + LOW_W'(1)};
            dec_o = {TID, low - LOW_W'(1)};
        end else begin
            inc_o = cur_o + IDX_W'(1);
            dec_o = cur_o - IDX_W'(1);
        end
    end

endmodule

// File: rtl/rsb_fill_seq.sv
module rsb_fill_seq #(
    parameter int ADDR_W     = 32,
    parameter int HALF_DEPTH = 16,
    parameter int FULL_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_i,
    input  logic              active_i,
    input  logic              dual_i,
    input  logic [ADDR_W-1:0] tgt_i,
    output logic              accept_o,
    output logic              busy_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] tgt_o
);

    localparam int CNT_W = $clog2(FULL_DEPTH + 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  left;
        logic [ADDR_W-1:0] tgt;
    } fill_state_t;

    fill_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        accept_o = fill_i && active_i && !st_q.busy;
        if (accept_o) begin
            st_d.busy = 1'b1;
            st_d.left = dual_i ? CNT_W'(HALF_DEPTH) : CNT_W'(FULL_DEPTH);
            st_d.tgt  = tgt_i;
        end else if (st_q.busy && active_i) begin
            st_d.left = st_q.left - CNT_W'(1);
            if (st_q.left == CNT_W'(1)) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign wr_o   = st_q.busy && active_i;
    assign tgt_o  = st_q.tgt;

    AST_FILL_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && active_i && !busy_o) |=> busy_o); // R10

    AST_FILL_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (st_q.left != '0)); // R10

    AST_FILL_PAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !active_i) |=> (busy_o && $stable(tgt_o))); // R10

endmodule

// File: rtl/smt_ret_stack.sv
module smt_ret_stack #(
    parameter int ADDR_W     = 32,
    parameter int HALF_DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          active_i,
    input  logic [1:0]          push_i,
    input  logic [2*ADDR_W-1:0] push_tgt_i,
    input  logic [1:0]          pop_i,
    input  logic [1:0]          fill_i,
    input  logic [ADDR_W-1:0]   fill_tgt_i,
    output logic [1:0]          pred_vld_o,
    output logic [2*ADDR_W-1:0] pred_tgt_o,
    output logic [1:0]          fill_busy_o
);

    import smt_rs_pkg::*;

    localparam int N_ENT = NUM_THREADS * HALF_DEPTH;
    localparam int IDX_W = $clog2(N_ENT);
    localparam int LOW_W = IDX_W - 1;

    typedef struct packed {
        logic [N_ENT-1:0][ADDR_W-1:0]       mem;
        logic [NUM_THREADS-1:0][IDX_W-1:0]  ptr;
        logic [NUM_THREADS-1:0]             vld;
        logic [NUM_THREADS-1:0][ADDR_W-1:0] tgt;
    } rs_state_t;

    rs_state_t st_d, st_q;

    logic                               dual, dual_prev, enter_dual;
    logic [NUM_THREADS-1:0][IDX_W-1:0]  cur_ptr, inc_ptr, dec_ptr;
    logic [NUM_THREADS-1:0]             fill_acc, fill_busy, fill_wr;
    logic [NUM_THREADS-1:0][ADDR_W-1:0] fill_tgt;

    rsb_mode_track u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (active_i),
        .dual_o      (dual),
        .dual_prev_o (dual_prev),
        .enter_dual_o(enter_dual)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        rsb_ptr_step #(
            .IDX_W    (IDX_W),
            .THREAD_ID(t)
        ) u_step (
            .ptr_i  (st_q.ptr[t]),
            .dual_i (dual),
            .remap_i(enter_dual),
            .cur_o  (cur_ptr[t]),
            .inc_o  (inc_ptr[t]),
            .dec_o  (dec_ptr[t])
        );

        rsb_fill_seq #(
            .ADDR_W    (ADDR_W),
            .HALF_DEPTH(HALF_DEPTH),
            .FULL_DEPTH(N_ENT)
        ) u_fill (
            .clk     (clk),
            .rst_n   (rst_n),
            .fill_i  (fill_i[t]),
            .active_i(active_i[t]),
            .dual_i  (dual),
            .tgt_i   (fill_tgt_i),
            .accept_o(fill_acc[t]),
            .busy_o  (fill_busy[t]),
            .wr_o    (fill_wr[t]),
            .tgt_o   (fill_tgt[t])
        );
    end

    always_comb begin
        stack_op_e op;
        st_d     = st_q;
        st_d.vld = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            st_d.ptr[t] = cur_ptr[t];
            op = stack_op_e'({push_i[t], pop_i[t]});
            if (fill_wr[t]) begin
                st_d.ptr[t]             = inc_ptr[t];
                st_d.mem[inc_ptr[t]]    = fill_tgt[t];
            end else if (active_i[t] && !fill_busy[t] && !fill_acc[t]) begin
                unique case (op)
                    OP_BOTH: begin
                        st_d.vld[t] = 1'b1;
                        st_d.tgt[t] = push_tgt_i[t*ADDR_W +: ADDR_W];
                    end
                    OP_PUSH: begin
                        st_d.ptr[t]          = inc_ptr[t];
                        st_d.mem[inc_ptr[t]] = push_tgt_i[t*ADDR_W +: ADDR_W];
                    end
                    OP_POP: begin
                        st_d.vld[t] = 1'b1;
                        st_d.tgt[t] = st_q.mem[cur_ptr[t]];
                        st_d.ptr[t] = dec_ptr[t];
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int t = 0; t < NUM_THREADS; t++) begin
                st_q.ptr[t] <= {1'(t), {LOW_W{1'b1}}};
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign pred_vld_o  = st_q.vld;
    assign pred_tgt_o  = st_q.tgt;
    assign fill_busy_o = fill_busy;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
        AST_POP_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
            (active_i[t] && pop_i[t] && !fill_busy_o[t] && !fill_acc[t])
            |=> pred_vld_o[t]); // R4

        AST_VLD_HAS_POP: assert property (@(posedge clk) disable iff (!rst_n)
            pred_vld_o[t] |-> $past(pop_i[t])); // R4

        AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            !active_i[t] |=> !pred_vld_o[t]); // R9

        AST_FILL_MUTES_POP: assert property (@(posedge clk) disable iff (!rst_n)
            fill_busy_o[t] |=> !pred_vld_o[t]); // R11

        AST_BYPASS_TGT: assert property (@(posedge clk) disable iff (!rst_n)
            (active_i[t] && push_i[t] && pop_i[t] && !fill_busy_o[t] && !fill_acc[t])
            |=> (pred_tgt_o[t*ADDR_W +: ADDR_W] == $past(push_tgt_i[t*ADDR_W +: ADDR_W]))); // R5

        AST_DUAL_OWN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
            (dual && dual_prev) |-> (st_q.ptr[t][IDX_W-1] == 1'(t))); // R1
    end

endmodule

// File: tb/smt_ret_stack_tb_top.sv
module smt_ret_stack_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  active_i = 2'b11;
    logic [1:0]  push_i = '0;
    logic [63:0] push_tgt_i = '0;
    logic [1:0]  pop_i = '0;
    logic [1:0]  fill_i = '0;
    logic [31:0] fill_tgt_i = '0;
    logic [1:0]  pred_vld_o;
    logic [63:0] pred_tgt_o;
    logic [1:0]  fill_busy_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    smt_ret_stack dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active_i),
        .push_i     (push_i),
        .push_tgt_i (push_tgt_i),
        .pop_i      (pop_i),
        .fill_i     (fill_i),
        .fill_tgt_i (fill_tgt_i),
        .pred_vld_o (pred_vld_o),
        .pred_tgt_o (pred_tgt_o),
        .fill_busy_o(fill_busy_o)
    );

    // behavioural reference model
    logic [31:0] m_mem [32];
    int          m_ptr [2];
    bit          m_vld [2];
    logic [31:0] m_tgt [2];
    bit          m_busy [2];
    int          m_left [2];
    logic [31:0] m_ftgt [2];
    bit          m_dual_prev;

    function automatic int step_up(int t, int p, bit d);
        return d ? t * 16 + ((p % 16) + 1) % 16 : (p + 1) % 32;
    endfunction

    function automatic int step_down(int t, int p, bit d);
        return d ? t * 16 + ((p % 16) + 15) % 16 : (p + 31) % 32;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = '0;
            m_ptr[0] = 15; m_ptr[1] = 31;
            for (int t = 0; t < 2; t++) begin
                m_vld[t] = 0; m_tgt[t] = '0; m_busy[t] = 0; m_left[t] = 0;
            end
            m_dual_prev = 0;
        end else begin
            bit d;
            d = (active_i == 2'b11);
            for (int t = 0; t < 2; t++) begin
                if (d && !m_dual_prev) m_ptr[t] = t * 16 + m_ptr[t] % 16;
            end
            for (int t = 0; t < 2; t++) begin
                m_vld[t] = 0;
                if (m_busy[t]) begin
                    if (active_i[t]) begin
                        m_ptr[t] = step_up(t, m_ptr[t], d);
                        m_mem[m_ptr[t]] = m_ftgt[t];
                        m_left[t]--;
                        if (m_left[t] == 0) m_busy[t] = 0;
                    end
                end else if (active_i[t]) begin
                    if (fill_i[t]) begin
                        m_busy[t] = 1; m_left[t] = d ? 16 : 32; m_ftgt[t] = fill_tgt_i;
                    end else if (push_i[t] && pop_i[t]) begin
                        m_vld[t] = 1; m_tgt[t] = push_tgt_i[t*32 +: 32];
                    end else if (push_i[t]) begin
                        m_ptr[t] = step_up(t, m_ptr[t], d);
                        m_mem[m_ptr[t]] = push_tgt_i[t*32 +: 32];
                    end else if (pop_i[t]) begin
                        m_vld[t] = 1; m_tgt[t] = m_mem[m_ptr[t]];
                        m_ptr[t] = step_down(t, m_ptr[t], d);
                    end
                end
            end
            m_dual_prev = d;
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            for (int t = 0; t < 2; t++) begin
                chk("R4 model valid", 64'(pred_vld_o[t]), 64'(m_vld[t]));
                if (m_vld[t]) chk("R3 model target", 64'(pred_tgt_o[t*32 +: 32]), 64'(m_tgt[t]));
                chk("R10 model busy", 64'(fill_busy_o[t]), 64'(m_busy[t]));
            end
        end
    end

    task automatic cyc(input logic [1:0] pu, input logic [1:0] po, input logic [1:0] fl,
                       input logic [31:0] a0, input logic [31:0] a1);
        @(negedge clk);
        push_i = pu; pop_i = po; fill_i = fl; push_tgt_i = {a1, a0};
        @(posedge clk);
        #5;
        push_i = '0; pop_i = '0; fill_i = '0;
    endtask

    task automatic pop_expect(int t, logic [31:0] exp, string req);
        cyc('0, 2'(1 << t), '0, '0, '0);
        chk(req, {pred_vld_o[t], pred_tgt_o[t*32 +: 32]}, {1'b1, exp});
    endtask

    task automatic fill_run(int t, logic [31:0] tgt, int exp_len, string req);
        int len = 0;
        fill_tgt_i = tgt;
        cyc('0, '0, 2'(1 << t), '0, '0);
        while (fill_busy_o[t] && len < 100) begin
            cyc('0, 2'(1 << t), '0, '0, '0);
            chk("R11 pop held off during fill", 64'(pred_vld_o[t]), 64'd0);
            len++;
        end
        chk(req, 64'(len), 64'(exp_len));
    endtask

    initial begin
        #(20 * 100000);
        n_err++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        chk("R4 reset valid", 64'(pred_vld_o), 64'd0);
        chk("R10 reset busy", 64'(fill_busy_o), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // dual-mode private stacks
        cyc(2'b01, '0, '0, 32'hA1, '0);
        cyc(2'b11, '0, '0, 32'hA2, 32'hB1);
        pop_expect(0, 32'hA2, "R3 lifo newest");
        pop_expect(1, 32'hB1, "R1 private half");
        pop_expect(0, 32'hA1, "R3 lifo older");

        // push and pop together
        cyc(2'b01, '0, '0, 32'hA3, '0);
        cyc(2'b01, 2'b01, '0, 32'hC5, '0);
        chk("R5 bypass value", {pred_vld_o[0], pred_tgt_o[31:0]}, {1'b1, 32'hC5});
        pop_expect(0, 32'hA3, "R5 stack unchanged");

        // overflow and wrap of thread 1 half
        for (int i = 1; i <= 17; i++) cyc(2'b10, '0, '0, '0, 32'h100 + i);
        pop_expect(1, 32'h111, "R6 newest after overflow");
        for (int i = 0; i < 14; i++) cyc('0, 2'b10, '0, '0, '0);
        pop_expect(1, 32'h102, "R6 oldest survivor");
        pop_expect(1, 32'h111, "R6 circular underflow");

        // stale entry reached right after entering single mode
        cyc(2'b01, '0, '0, 32'hA7, '0);
        active_i = 2'b01;
        pop_expect(0, 32'hA7, "R8 own entry first");
        pop_expect(0, 32'h110, "R8 sibling stale entry");
        cyc(2'b10, 2'b10, '0, '0, 32'hDEAD);
        chk("R9 idle pop ignored", 64'(pred_vld_o[1]), 64'd0);
        cyc(2'b10, '0, '0, '0, 32'hBEEF);

        // 32-entry single stack
        for (int i = 1; i <= 20; i++) cyc(2'b01, '0, '0, 32'h200 + i, '0);
        pop_expect(0, 32'h214, "R2 newest in unified stack");
        for (int i = 0; i < 18; i++) cyc('0, 2'b01, '0, '0, '0);
        pop_expect(0, 32'h201, "R2 twentieth entry back");

        // return to dual mode
        active_i = 2'b11;
        pop_expect(1, 32'h201, "R7 entries kept and R9 idle push ignored");
        pop_expect(0, 32'h210, "R7 pointer folded into own half");

        // fill in dual mode
        fill_run(0, 32'h5AFE, 16, "R10 dual fill length");
        for (int i = 0; i < 16; i++) pop_expect(0, 32'h5AFE, "R10 dual fill content");
        pop_expect(1, 32'h10F, "R1 sibling untouched by fill");

        // fill in single mode
        active_i = 2'b10;
        fill_run(1, 32'h7777, 32, "R10 single fill length");
        cyc(2'b10, '0, 2'b10, '0, 32'h999);
        chk("R11 push ignored on fill accept", 64'(fill_busy_o[1]), 64'd1);
        for (int i = 0; i < 40; i++) cyc('0, '0, '0, '0, '0);
        pop_expect(1, 32'h7777, "R11 accept-cycle push dropped");
        active_i = 2'b11;
        pop_expect(0, 32'h7777, "R10 single fill reaches other half");

        repeat (3) @(posedge clk);
        #6;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule